// File: doc/BRIEF.md
# Stereo PCM Serial Output

This block takes one 16-bit left sample and one 16-bit right sample per sample period and shifts them out on three wires: a bit clock, a word clock that marks the channel, and a serial data line. A fourth output carries an error flag for each sample. The flag is high while the bits of a sample that upstream logic marked as uncorrectable are on the data line. A single-cycle sample-rate tick starts each frame. The bit clock is divided from the system clock by a parameter, so a faster tick and a smaller divider give faster-than-normal playback.

The frame length is set per frame to 32, 48 or 64 bit clocks. Each channel slot holds the 16 data bits first, followed by zero padding. The word-clock level can be inverted, and the bit order can be MSB first or LSB first. The samples, flags and all control inputs are captured at the start of a frame. Changes to the inputs during a frame therefore take effect only in the next frame.

Top module: `pcm_serializer`

## Requirements
- R1: While reset is asserted and after its release, `bck`, `wck`, `sdata` and `bad_out` are all low until the first frame starts.
- R2: A frame starts on the clock edge that samples `fs_tick` high while the block is idle. Each bit lasts 2*HALF_CYC system clocks. `bck` is low for the first HALF_CYC of these clocks and high for the rest.
- R3: `ratio_sel` sets the slot length per channel: 0 gives 16 bit clocks, 1 gives 24, and 2 or 3 gives 32. A frame is two slots, left then right, with exactly that many rising `bck` edges.
- R4: With `lr_invert`=0, `wck` is low during the left slot and high during the right slot. With `lr_invert`=1 both levels are inverted.
- R5: Bits 0..15 of a slot carry the sample: with `lsb_first`=0, slot bit k is sample bit 15-k; with `lsb_first`=1, it is sample bit k. Slot bits 16 and above are 0.
- R6: `sdata` and `wck` change only while `bck` is low (on its falling edge, or at frame start) and are stable across each rising edge of `bck`.
- R7: `bad_out` is high during the 16 data bits of a channel whose flag (`left_bad` or `right_bad`) was set, and low during padding bits and during the other channel's slot.
- R8: The samples, flags, `ratio_sel`, `lr_invert` and `lsb_first` are captured at frame start. Changing them during a frame does not alter that frame.
- R9: A tick that arrives while a frame is in progress is ignored and does not start another frame.
- R10: After the last bit the block returns to idle. `bck`, `sdata` and `bad_out` stay low with no `bck` edges, and `wck` holds the level of the right slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fs_tick | input | 1 | One-cycle sample-rate strobe that starts a frame |
| left_in | input | 16 | Left PCM sample |
| right_in | input | 16 | Right PCM sample |
| left_bad | input | 1 | Left sample is uncorrectable |
| right_bad | input | 1 | Right sample is uncorrectable |
| ratio_sel | input | 2 | Bit clocks per frame: 0=32, 1=48, 2/3=64 |
| lr_invert | input | 1 | Inverts the word-clock level |
| lsb_first | input | 1 | 1 selects LSB-first bit order |
| bck | output | 1 | Bit clock |
| wck | output | 1 | Word (channel) clock |
| sdata | output | 1 | Serial data |
| bad_out | output | 1 | Error flag aligned with the data bits |

## Verification
The assertions check the following on every cycle:
- the bit clock is quiet while idle;
- data and word clock are stable at each rising bit-clock edge;
- the error flag is high only inside a frame;
- the bit index stays within the selected frame length;
- the captured samples do not move during a frame.

Only the bench's scenarios can show the following, because they must be checked against the requirement-derived expectation for each slot:
- the bit value and bit order;
- the word-clock level for each polarity;
- where the error flag sits within a slot;
- the rising-edge count for each ratio code;
- that mid-frame input changes and stray ticks leave the output unchanged.

// File: rtl/pcm_ser_pkg.sv
package pcm_ser_pkg;
  localparam int SAMPLE_W = 16;
  localparam int MAX_SLOT = 32;
  localparam int FBIT_W   = $clog2(2 * MAX_SLOT);
  localparam int IDX_W    = $clog2(SAMPLE_W);

  typedef enum logic [1:0] {
    RATIO_32  = 2'd0,
    RATIO_48  = 2'd1,
    RATIO_64  = 2'd2,
    RATIO_64X = 2'd3
  } ratio_e;

  function automatic logic [FBIT_W-1:0] slot_len(input logic [1:0] sel);
    case (ratio_e'(sel))
      RATIO_32: slot_len = FBIT_W'(16);
      RATIO_48: slot_len = FBIT_W'(24);
      default:  slot_len = FBIT_W'(MAX_SLOT);
    endcase
  endfunction

  function automatic logic [FBIT_W-1:0] final_bit(input logic [1:0] sel);
    case (ratio_e'(sel))
      RATIO_32: final_bit = FBIT_W'(31);
      RATIO_48: final_bit = FBIT_W'(47);
      default:  final_bit = FBIT_W'(2 * MAX_SLOT - 1);
    endcase
  endfunction
endpackage

// File: rtl/pcm_ser_bitclk.sv
module pcm_ser_bitclk #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic bck,
  output logic bit_end
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             bck_q;
  logic             wrap;

  always_comb begin
    wrap    = (cnt_q == CNT_TOP);
    bit_end = run && !start && wrap && bck_q;
  end

  always_ff @(posedge clk) begin
    if (rst || start || !run) begin
      cnt_q <= '0;
      bck_q <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      bck_q <= ~bck_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bck = bck_q;

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    start |=> !bck_q); // R2
endmodule

// File: rtl/pcm_ser_frame.sv
module pcm_ser_frame
  import pcm_ser_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                bit_end,
  input  logic [SAMPLE_W-1:0] smp_l,
  input  logic [SAMPLE_W-1:0] smp_r,
  input  logic                flag_l,
  input  logic                flag_r,
  input  logic [1:0]          ratio,
  input  logic                lr_inv,
  input  logic                lsb_first,
  output logic                active,
  output logic                sdata,
  output logic                wck,
  output logic                eflag
);
  logic [SAMPLE_W-1:0] l_q, r_q;
  logic                fl_q, fr_q, inv_q, lsbf_q;
  logic [1:0]          ratio_q;
  logic [FBIT_W-1:0]   fbit_q;
  logic                act_q, sd_q, wck_q, ef_q;

  logic [SAMPLE_W-1:0] use_l, use_r, word;
  logic                use_fl, use_fr, use_inv, use_lsbf, flag;
  logic [1:0]          use_ratio;
  logic [FBIT_W-1:0]   nbit, slot, pos;
  logic [IDX_W-1:0]    idx;
  logic                in_right, in_data, last;
  logic                nxt_sd, nxt_wck, nxt_ef;

  always_comb begin
    use_l     = start ? smp_l     : l_q;
    use_r     = start ? smp_r     : r_q;
    use_fl    = start ? flag_l    : fl_q;
    use_fr    = start ? flag_r    : fr_q;
    use_ratio = start ? ratio     : ratio_q;
    use_inv   = start ? lr_inv    : inv_q;
    use_lsbf  = start ? lsb_first : lsbf_q;
    nbit      = start ? '0 : fbit_q + 1'b1;
    slot      = slot_len(use_ratio);
    in_right  = (nbit >= slot);
    pos       = in_right ? nbit - slot : nbit;
    word      = in_right ? use_r : use_l;
    flag      = in_right ? use_fr : use_fl;
    in_data   = (pos < FBIT_W'(SAMPLE_W));
    idx       = use_lsbf ? pos[IDX_W-1:0] : IDX_W'(SAMPLE_W - 1) - pos[IDX_W-1:0];
    nxt_sd    = in_data && word[idx];
    nxt_ef    = in_data && flag;
    nxt_wck   = in_right ^ use_inv;
    last      = (fbit_q == final_bit(ratio_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_q     <= '0;
      r_q     <= '0;
      fl_q    <= 1'b0;
      fr_q    <= 1'b0;
      inv_q   <= 1'b0;
      lsbf_q  <= 1'b0;
      ratio_q <= 2'd0;
      fbit_q  <= '0;
      act_q   <= 1'b0;
      sd_q    <= 1'b0;
      wck_q   <= 1'b0;
      ef_q    <= 1'b0;
    end else if (start) begin
      l_q     <= smp_l;
      r_q     <= smp_r;
      fl_q    <= flag_l;
      fr_q    <= flag_r;
      inv_q   <= lr_inv;
      lsbf_q  <= lsb_first;
      ratio_q <= ratio;
      fbit_q  <= '0;
      act_q   <= 1'b1;
      sd_q    <= nxt_sd;
      wck_q   <= nxt_wck;
      ef_q    <= nxt_ef;
    end else if (bit_end) begin
      if (last) begin
        act_q <= 1'b0;
        sd_q  <= 1'b0;
        ef_q  <= 1'b0;
      end else begin
        fbit_q <= nbit;
        sd_q   <= nxt_sd;
        wck_q  <= nxt_wck;
        ef_q   <= nxt_ef;
      end
    end
  end

  assign active = act_q;
  assign sdata  = sd_q;
  assign wck    = wck_q;
  assign eflag  = ef_q;

  AST_FBIT_BOUND: assert property (@(posedge clk) disable iff (rst)
    act_q |-> (fbit_q <= final_bit(ratio_q))); // R3

  AST_SAMPLES_HELD: assert property (@(posedge clk) disable iff (rst)
    act_q |=> (!act_q || ($stable(l_q) && $stable(r_q) && $stable(ratio_q)))); // R8
endmodule

// File: rtl/pcm_serializer.sv
module pcm_serializer
  import pcm_ser_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fs_tick,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                left_bad,
  input  logic                right_bad,
  input  logic [1:0]          ratio_sel,
  input  logic                lr_invert,
  input  logic                lsb_first,
  output logic                bck,
  output logic                wck,
  output logic                sdata,
  output logic                bad_out
);
  logic active, start, bit_end;

  assign start = fs_tick && !active;

  pcm_ser_bitclk #(.HALF_CYC(HALF_CYC)) u_bitclk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .run     (active),
    .bck     (bck),
    .bit_end (bit_end)
  );

  pcm_ser_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bit_end   (bit_end),
    .smp_l     (left_in),
    .smp_r     (right_in),
    .flag_l    (left_bad),
    .flag_r    (right_bad),
    .ratio     (ratio_sel),
    .lr_inv    (lr_invert),
    .lsb_first (lsb_first),
    .active    (active),
    .sdata     (sdata),
    .wck       (wck),
    .eflag     (bad_out)
  );

  AST_BCK_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    !active |-> !bck); // R10

  AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(bck) |-> ($stable(sdata) && $stable(wck))); // R6

  AST_FLAG_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    bad_out |-> active); // R7
endmodule

// File: tb/pcm_serializer_tb.sv
module pcm_serializer_tb;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fs_tick = 1'b0;
  logic [15:0] left_in = '0, right_in = '0;
  logic        left_bad = 1'b0, right_bad = 1'b0;
  logic [1:0]  ratio_sel = 2'd0;
  logic        lr_invert = 1'b0, lsb_first = 1'b0;
  logic        bck, wck, sdata, bad_out;

  int total = 0;
  int fails = 0;
  int rises = 0;

  always #10 clk = ~clk;
  always @(posedge bck) rises++;

  pcm_serializer #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst(rst), .fs_tick(fs_tick),
    .left_in(left_in), .right_in(right_in),
    .left_bad(left_bad), .right_bad(right_bad),
    .ratio_sel(ratio_sel), .lr_invert(lr_invert), .lsb_first(lsb_first),
    .bck(bck), .wck(wck), .sdata(sdata), .bad_out(bad_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) fs_tick = 1'b1;
    @(negedge clk) fs_tick = 1'b0;
  endtask

  // Plays one frame and compares every bit against the requirement model.
  task automatic play(input logic [15:0] l, input logic [15:0] r,
                      input bit fl, input bit fr, input logic [1:0] sel,
                      input bit inv, input bit lsbf,
                      input bit mid_change, input bit mid_tick, input string tag);
    int slot, r0, bad_d, bad_w, bad_e;
    logic [15:0] w;
    @(negedge clk);
    left_in = l; right_in = r; left_bad = fl; right_bad = fr;
    ratio_sel = sel; lr_invert = inv; lsb_first = lsbf;
    slot = (sel == 2'd0) ? 16 : (sel == 2'd1) ? 24 : 32;
    r0 = rises;
    bad_d = 0; bad_w = 0; bad_e = 0;
    pulse_tick();
    for (int k = 0; k < 2 * slot; k++) begin
      int p;
      bit ch, eb, ee;
      @(posedge bck);
      ch = (k >= slot);
      p  = ch ? k - slot : k;
      w  = ch ? r : l;
      eb = (p < 16) ? (lsbf ? w[p] : w[15 - p]) : 1'b0;
      ee = (p < 16) && (ch ? fr : fl);
      if (sdata !== eb) bad_d++;
      if (wck !== (ch ^ inv)) bad_w++;
      if (bad_out !== ee) bad_e++;
      if (mid_change && k == 4) begin
        @(negedge clk);
        left_in = ~l; right_in = ~r; left_bad = ~fl; right_bad = ~fr;
        lsb_first = ~lsbf; lr_invert = ~inv;
      end
      if (mid_tick && k == 6) pulse_tick();
    end
    chk(bad_d == 0, {tag, " R5 data bits"}, bad_d, 0);
    chk(bad_w == 0, {tag, " R4 word clock"}, bad_w, 0);
    chk(bad_e == 0, {tag, " R7 error flag"}, bad_e, 0);
    repeat (4 * HALF) @(negedge clk);
    chk(rises - r0 == 2 * slot, {tag, " R3 bck edges per frame"}, rises - r0, 2 * slot);
    chk(!bck && !sdata && !bad_out && (wck == !inv), {tag, " R10 idle outputs"},
        {bck, sdata, bad_out, wck}, {3'b000, !inv});
  endtask

  task automatic t_reset();
    chk({bck, wck, sdata, bad_out} == 4'b0, "R1 reset outputs", {bck, wck, sdata, bad_out}, 0);
  endtask

  task automatic t_bck_timing();
    @(negedge clk);
    ratio_sel = 2'd0;
    pulse_tick();
    repeat (HALF - 1) @(negedge clk);
    chk(bck == 1'b0, "R2 bck low first half", bck, 0);
    @(negedge clk);
    chk(bck == 1'b1, "R2 bck high second half", bck, 1);
    repeat (HALF) @(negedge clk);
    chk(bck == 1'b0, "R2 bck falls after bit period", bck, 0);
    repeat (2 * HALF * 32 + 4) @(negedge clk);
  endtask

  task automatic t_idle_quiet();
    int r0;
    r0 = rises;
    repeat (50) @(negedge clk);
    chk(rises == r0 && !bck, "R10 no bck edges when idle", rises - r0, 0);
  endtask

  task automatic t_tick_ignored();
    play(16'h0F0F, 16'h3C3C, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 stray tick");
    t_idle_quiet();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog R2 run did not finish actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_bck_timing();
    play(16'hA5C3, 16'h1234, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "32fs msb");
    play(16'h8001, 16'h7FFE, 1'b1, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, "48fs lsb");
    play(16'hFFFF, 16'h00FF, 1'b0, 1'b1, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, "64fs inv");
    play(16'h6B29, 16'hD00D, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, "code3 R3");
    play(16'hC001, 16'h5AA5, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, "R8 mid-frame change");
    t_tick_ignored();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule